// File: doc/BRIEF.md
# Looping Audio DMA Channel Controller

This block computes memory addresses and counts bytes for two audio streams, one for playback (stream 0) and one for capture (stream 1). Software sets a base address, a buffer byte count and a period byte count for each stream, picks a sample format and starts the stream. A transfer strobe marks each moved sample word. On each strobe the block moves the stream's memory address forward by one word and counts the word against the buffer and the period.

At the end of a period the block can raise a per-stream flag. At the end of the buffer it either wraps to the base address (loop mode) or stops the stream and reports the stop. A shared status register holds the period flags and two bus-error flags. Software clears them by writing ones, and their OR (errors gated by their own enables) drives one interrupt line. Software reads the current address to find the stream's position in its buffer.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset every register reads 0, both memory address outputs are 0 and `irq_o` is low.
- R2: Register word index s*8+n belongs to stream s. n=1, 3 and 5 are the base address, base buffer count and base period count. A write to one of these loads the same value into the base copy and into its current copy (n=2, 4 and 6). The current copies ignore direct writes.
- R3: Control (n=0) has these bits: bit0 run, bit1 loop, bit2 period-interrupt enable, bit3 wide, bit4 stereo, bit7 channel-reset strobe. The word size is 1<<(wide+stereo) bytes. Each strobe while run is set adds one word to the current address and takes one word off both current counts. The stream's memory address output equals its current address.
- R4: A strobe that takes the current period count to zero reloads it from the base period count. If the period-interrupt enable is set, it also sets the stream's period flag.
- R5: In loop mode, a strobe that takes the current buffer count to zero reloads the current address and the current buffer count from their base copies.
- R6: Without loop mode, that strobe leaves the address one word past the buffer and the buffer count at 0. It clears run and sets the stream's bit in the channel status register (index 17). Later strobes have no effect.
- R7: The status register (index 16) has these bits: bits 0-1 period flags of streams 0-1, bit2 master abort, bit3 target abort, bits 8-9 enables for the two error flags. A 1 written to bits 0-3 clears that flag, and bits 8-9 take the written value. `irq_o` is the OR of the period flags and of each error flag ANDed with its enable.
- R8: If a clearing write and a new event for the same flag fall in the same cycle, the flag stays set.
- R9: A control write with bit7 set clears run and the period-interrupt enable and zeroes all six address and count registers of that stream.
- R10: Strobes and register writes on one stream leave the other stream's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| xfer_i | input | 2 | Per-stream strobe, one moved sample word |
| master_abort_i | input | 1 | Bus master-abort event |
| target_abort_i | input | 1 | Bus target-abort event |
| mem_addr_o | output | 64 | Current address of stream 0 (low half) and stream 1 (high half) |
| irq_o | output | 1 | Interrupt request |

## Verification
A fault in a stream's address adder or count subtractors shows on `mem_addr_o` and on the current-count read-back in the cycle after the strobe that goes through the fault. A wrong terminal compare shows up at a period or buffer boundary as a missing or early flag, a missed reload or a wrong stop. The sweep covers every word size, both loop settings and several buffer-to-period ratios, so each boundary is crossed more than once within two buffer lengths. A fault in the status merge or the clear logic shows on `irq_o` the cycle after the event or the clearing write.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;
  localparam int IDX_CTRL     = 0;
  localparam int IDX_BASE_ADR = 1;
  localparam int IDX_CUR_ADR  = 2;
  localparam int IDX_BASE_BUF = 3;
  localparam int IDX_CUR_BUF  = 4;
  localparam int IDX_BASE_PER = 5;
  localparam int IDX_CUR_PER  = 6;

  localparam int CB_RUN    = 0;
  localparam int CB_LOOP   = 1;
  localparam int CB_IRQEN  = 2;
  localparam int CB_WIDE   = 3;
  localparam int CB_STEREO = 4;
  localparam int CB_RESET  = 7;

  localparam int ERR_EN_LSB = 8;

  typedef struct packed {
    logic run;
    logic loop;
    logic irq_en;
    logic wide;
    logic stereo;
  } ctrl_t;

  function automatic logic [2:0] word_bytes(input logic wide, input logic stereo);
    return 3'd1 << ({1'b0, wide} + {1'b0, stereo});
  endfunction
endpackage

// File: rtl/audio_dma_stream.sv
module audio_dma_stream
  import audio_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        idx_i,
  input  logic [31:0]       wdata_i,
  input  logic              xfer_i,
  output logic              period_evt_o,
  output logic              stop_evt_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [31:0]       rdata_o
);
  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] base_addr_q, cur_addr_q;
  logic [CNT_W-1:0]  base_buf_q, cur_buf_q, base_per_q, cur_per_q;

  logic [2:0]        step;
  logic [ADDR_W-1:0] step_a;
  logic [CNT_W-1:0]  step_c;
  logic              active, per_end, buf_end, ctrl_wr;

  assign step    = word_bytes(ctrl_q.wide, ctrl_q.stereo);
  assign step_a  = ADDR_W'(step);
  assign step_c  = CNT_W'(step);
  assign ctrl_wr = wr_i && (idx_i == 3'(IDX_CTRL));
  // control write takes the cycle; a coincident strobe is dropped
  assign active  = ctrl_q.run && xfer_i && !ctrl_wr;
  assign per_end = active && (cur_per_q <= step_c);
  assign buf_end = active && (cur_buf_q <= step_c);

  assign period_evt_o = per_end && ctrl_q.irq_en;
  assign stop_evt_o   = buf_end && !ctrl_q.loop;
  assign cur_addr_o   = cur_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_buf_q  <= '0;
      cur_buf_q   <= '0;
      base_per_q  <= '0;
      cur_per_q   <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.loop   <= wdata_i[CB_LOOP];
      ctrl_q.wide   <= wdata_i[CB_WIDE];
      ctrl_q.stereo <= wdata_i[CB_STEREO];
      if (wdata_i[CB_RESET]) begin
        ctrl_q.run    <= 1'b0;
        ctrl_q.irq_en <= 1'b0;
        base_addr_q   <= '0;
        cur_addr_q    <= '0;
        base_buf_q    <= '0;
        cur_buf_q     <= '0;
        base_per_q    <= '0;
        cur_per_q     <= '0;
      end else begin
        ctrl_q.run    <= wdata_i[CB_RUN];
        ctrl_q.irq_en <= wdata_i[CB_IRQEN];
      end
    end else begin
      if (active) begin
        cur_addr_q <= (buf_end && ctrl_q.loop) ? base_addr_q : cur_addr_q + step_a;
        cur_buf_q  <= buf_end ? (ctrl_q.loop ? base_buf_q : '0) : cur_buf_q - step_c;
        cur_per_q  <= per_end ? base_per_q : cur_per_q - step_c;
        if (buf_end && !ctrl_q.loop) ctrl_q.run <= 1'b0;
      end
      if (wr_i && idx_i == 3'(IDX_BASE_ADR)) begin
        base_addr_q <= wdata_i[ADDR_W-1:0];
        cur_addr_q  <= wdata_i[ADDR_W-1:0];
      end
      if (wr_i && idx_i == 3'(IDX_BASE_BUF)) begin
        base_buf_q <= wdata_i[CNT_W-1:0];
        cur_buf_q  <= wdata_i[CNT_W-1:0];
      end
      if (wr_i && idx_i == 3'(IDX_BASE_PER)) begin
        base_per_q <= wdata_i[CNT_W-1:0];
        cur_per_q  <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      3'(IDX_CTRL): begin
        rdata_o[CB_RUN]    = ctrl_q.run;
        rdata_o[CB_LOOP]   = ctrl_q.loop;
        rdata_o[CB_IRQEN]  = ctrl_q.irq_en;
        rdata_o[CB_WIDE]   = ctrl_q.wide;
        rdata_o[CB_STEREO] = ctrl_q.stereo;
      end
      3'(IDX_BASE_ADR): rdata_o = 32'(base_addr_q);
      3'(IDX_CUR_ADR):  rdata_o = 32'(cur_addr_q);
      3'(IDX_BASE_BUF): rdata_o = 32'(base_buf_q);
      3'(IDX_CUR_BUF):  rdata_o = 32'(cur_buf_q);
      3'(IDX_BASE_PER): rdata_o = 32'(base_per_q);
      3'(IDX_CUR_PER):  rdata_o = 32'(cur_per_q);
      default:          rdata_o = '0;
    endcase
  end

  // R5
  buf_within_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_buf_q <= base_buf_q);

  // R4
  per_within_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_per_q <= base_per_q);

  // R6
  run_drop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.run) |-> $past(stop_evt_o || ctrl_wr));

  // R3
  idle_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_i) |=> $stable(cur_addr_q));
endmodule

// File: rtl/audio_dma_status.sv
module audio_dma_status
  import audio_dma_pkg::*;
#(
  parameter int NS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] period_evt_i,
  input  logic [NS-1:0] stop_evt_i,
  input  logic          mabort_i,
  input  logic          tabort_i,
  input  logic          stat_wr_i,
  input  logic          chst_wr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   stat_o,
  output logic [31:0]   chst_o,
  output logic          irq_o
);
  localparam int FW = NS + 2;

  logic [FW-1:0] flags_q, set_vec, clr_vec, en_mask;
  logic [1:0]    err_en_q;
  logic [NS-1:0] chst_q, chst_clr;

  assign set_vec  = {tabort_i, mabort_i, period_evt_i};
  assign clr_vec  = stat_wr_i ? wdata_i[FW-1:0] : '0;
  assign chst_clr = chst_wr_i ? wdata_i[NS-1:0] : '0;
  assign en_mask  = {err_en_q, {NS{1'b1}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      err_en_q <= '0;
      chst_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      chst_q  <= (chst_q & ~chst_clr) | stop_evt_i;
      if (stat_wr_i) err_en_q <= wdata_i[ERR_EN_LSB +: 2];
    end
  end

  assign irq_o = |(flags_q & en_mask);

  always_comb begin
    stat_o                  = '0;
    stat_o[FW-1:0]          = flags_q;
    stat_o[ERR_EN_LSB +: 2] = err_en_q;
    chst_o                  = '0;
    chst_o[NS-1:0]          = chst_q;
  end

  for (genvar i = 0; i < FW; i++) begin : g_flag_chk
    // R8
    event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[i] |=> flags_q[i]);
    // R7
    clear_only_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_q[i]) |-> $past(clr_vec[i]));
  end
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine
  import audio_dma_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int REG_AW      = 3 + $clog2(NUM_STREAMS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [REG_AW-1:0]             reg_addr_i,
  input  logic [31:0]                   reg_wdata_i,
  output logic [31:0]                   reg_rdata_o,
  input  logic [NUM_STREAMS-1:0]        xfer_i,
  input  logic                          master_abort_i,
  input  logic                          target_abort_i,
  output logic [NUM_STREAMS*ADDR_W-1:0] mem_addr_o,
  output logic                          irq_o
);
  localparam int BLK_W = REG_AW - 3;

  logic [BLK_W-1:0]       blk;
  logic [2:0]             idx;
  logic [NUM_STREAMS-1:0] period_evt, stop_evt;
  logic [31:0]            srd [NUM_STREAMS];
  logic [31:0]            stat_rd, chst_rd;
  logic                   stat_wr, chst_wr;

  assign blk = reg_addr_i[REG_AW-1:3];
  assign idx = reg_addr_i[2:0];

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic sel_wr;
    assign sel_wr = reg_we_i && (blk == BLK_W'(s));

    audio_dma_stream #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) i_stream (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (sel_wr),
      .idx_i        (idx),
      .wdata_i      (reg_wdata_i),
      .xfer_i       (xfer_i[s]),
      .period_evt_o (period_evt[s]),
      .stop_evt_o   (stop_evt[s]),
      .cur_addr_o   (mem_addr_o[s*ADDR_W +: ADDR_W]),
      .rdata_o      (srd[s])
    );
  end

  assign stat_wr = reg_we_i && (blk == BLK_W'(NUM_STREAMS)) && (idx == 3'd0);
  assign chst_wr = reg_we_i && (blk == BLK_W'(NUM_STREAMS)) && (idx == 3'd1);

  audio_dma_status #(
    .NS (NUM_STREAMS)
  ) i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_evt_i (period_evt),
    .stop_evt_i   (stop_evt),
    .mabort_i     (master_abort_i),
    .tabort_i     (target_abort_i),
    .stat_wr_i    (stat_wr),
    .chst_wr_i    (chst_wr),
    .wdata_i      (reg_wdata_i),
    .stat_o       (stat_rd),
    .chst_o       (chst_rd),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (blk == BLK_W'(s)) reg_rdata_o = srd[s];
    end
    if (blk == BLK_W'(NUM_STREAMS)) begin
      if (idx == 3'd0) reg_rdata_o = stat_rd;
      else if (idx == 3'd1) reg_rdata_o = chst_rd;
    end
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/test_audio_dma_engine.sv
module test_audio_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  xfer = '0;
  logic        mab = 1'b0, tab = 1'b0;
  logic [63:0] mem_addr;
  logic        irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_dma_engine i_audio_dma_engine (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .xfer_i (xfer),
    .master_abort_i (mab), .target_abort_i (tab), .mem_addr_o (mem_addr),
    .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = 5'(a); wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 5'(a);
    #1;
    d = rdata;
  endtask

  task automatic strobe(input int s);
    xfer[s] = 1'b1;
    tick();
    xfer = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 18; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 32'h0);
    end
    chk("R1 mem_addr lo", mem_addr[31:0], 32'h0);
    chk("R1 mem_addr hi", mem_addr[63:32], 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 base writes load both copies; current copies read-only
    wr(1, 32'hCAFE_0010);
    rd(1, v); chk("R2 base addr", v, 32'hCAFE_0010);
    rd(2, v); chk("R2 cur addr", v, 32'hCAFE_0010);
    wr(3, 32'h0000_0040);
    rd(4, v); chk("R2 cur buf", v, 32'h40);
    wr(5, 32'h0000_0010);
    rd(6, v); chk("R2 cur per", v, 32'h10);
    wr(2, 32'h1234_5678);
    rd(2, v); chk("R2 cur addr write ignored", v, 32'hCAFE_0010);
    wr(4, 32'h0000_0003);
    rd(4, v); chk("R2 cur buf write ignored", v, 32'h40);

    // R3 R4 R5 R6 R10 sweep
    for (int s = 0; s < 2; s++)
      for (int fmt = 0; fmt < 4; fmt++)
        for (int lp = 0; lp < 2; lp++)
          for (int bm = 3; bm <= 4; bm++)
            for (int pm = 1; pm <= 3; pm++) begin
              int step, bb, pp, nn;
              logic [31:0] aa, oth;
              step = 1 << ((fmt & 1) + (fmt >> 1));
              bb = bm * step;
              pp = pm * step;
              aa = 32'h1000 + 32'(s) * 32'h400 + 32'(fmt) * 32'h10;
              wr(s*8, 32'h80);
              wr(16, 32'h00F);
              wr(17, 32'h3);
              wr(s*8+1, aa);
              wr(s*8+3, 32'(bb));
              wr(s*8+5, 32'(pp));
              wr(s*8, 32'(1 | (lp << 1) | (1 << 2) | (fmt << 3)));
              oth = mem_addr[(1-s)*32 +: 32];
              nn = 2*bm + 1;
              for (int k = 1; k <= nn; k++) begin
                int eff, bytes;
                bit counted, pflag, runx, stopx;
                logic [31:0] ea, eb, ep;
                strobe(s);
                counted = (lp != 0) || (k <= bm);
                eff = (lp != 0) ? k : ((k < bm) ? k : bm);
                bytes = eff * step;
                ea = (lp != 0) ? aa + 32'((k*step) % bb) : aa + 32'(bytes);
                eb = (lp != 0) ? 32'(bb - (k*step) % bb) : 32'(bb - bytes);
                ep = 32'(pp - bytes % pp);
                pflag = counted && (bytes % pp == 0);
                runx = (lp != 0) || (k < bm);
                stopx = (lp == 0) && (k >= bm);
                chk("R3 mem_addr", mem_addr[s*32 +: 32], ea);
                rd(s*8+2, v); chk("R3 R5 cur addr", v, ea);
                rd(s*8+4, v); chk("R5 R6 cur buf", v, eb);
                rd(s*8+6, v); chk("R4 cur per", v, ep);
                rd(16, v);    chk("R4 period flag", {31'b0, v[s]}, {31'b0, pflag});
                chk("R7 irq follows flag", {31'b0, irq}, {31'b0, pflag});
                rd(s*8, v);   chk("R6 run bit", {31'b0, v[0]}, {31'b0, runx});
                rd(17, v);    chk("R6 channel status", {31'b0, v[s]}, {31'b0, stopx});
                chk("R10 other stream", mem_addr[(1-s)*32 +: 32], oth);
                if (pflag) wr(16, 32'(1 << s));
              end
            end

    // R4 no flag without period-interrupt enable, count still reloads
    wr(0, 32'h80);
    wr(16, 32'h00F);
    wr(1, 32'h2000);
    wr(3, 32'd8);
    wr(5, 32'd2);
    wr(0, 32'h0B);  // run, loop, wide
    for (int k = 1; k <= 3; k++) begin
      strobe(0);
      rd(16, v); chk("R4 masked flag", {31'b0, v[0]}, 32'h0);
      rd(6, v);  chk("R4 masked reload", v, 32'd2);
      chk("R4 masked irq", {31'b0, irq}, 32'h0);
    end

    // R7 error flags and enables
    wr(16, 32'h00F);
    mab = 1'b1; tick(); mab = 1'b0;
    rd(16, v); chk("R7 master flag", v, 32'h4);
    chk("R7 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(16, 32'h100);
    chk("R7 irq enabled master", {31'b0, irq}, 32'h1);
    // R8 clear and event same cycle
    we = 1'b1; addr = 5'd16; wdata = 32'h104; mab = 1'b1;
    tick();
    we = 1'b0; mab = 1'b0;
    rd(16, v); chk("R8 set wins", v, 32'h104);
    wr(16, 32'h104);
    rd(16, v); chk("R7 w1c master", v, 32'h100);
    chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    tab = 1'b1; tick(); tab = 1'b0;
    rd(16, v); chk("R7 target flag", v, 32'h108);
    chk("R7 target masked", {31'b0, irq}, 32'h0);
    wr(16, 32'h200);
    rd(16, v); chk("R7 enable swap", v, 32'h208);
    chk("R7 target irq", {31'b0, irq}, 32'h1);
    wr(16, 32'h008);
    chk("R7 target cleared irq", {31'b0, irq}, 32'h0);

    // R9 channel reset mid-run
    wr(8+1, 32'h3000);
    wr(8+3, 32'd16);
    wr(8+5, 32'd8);
    wr(8, 32'h07);
    strobe(1); strobe(1);
    chk("R9 pre-reset addr", mem_addr[63:32], 32'h3002);
    wr(8, 32'h87);
    for (int n = 1; n <= 6; n++) begin
      rd(8+n, v); chk($sformatf("R9 zeroed idx %0d", n), v, 32'h0);
    end
    rd(8, v); chk("R9 run and enable cleared", v & 32'h5, 32'h0);
    strobe(1);
    chk("R9 strobe after reset ignored", mem_addr[63:32], 32'h0);

    done = 1;
    finish_run();
  end
endmodule